// File: doc/BRIEF.md
# Maskable Clear-on-Read Interrupt Register

This block holds the event status and interrupt masking behind one 16-bit register of a PHY management register space. Up to eight event inputs each carry one-cycle pulses. A pulse sets a sticky status bit, and that bit stays set until software reads the interrupt register. The upper byte of the same register holds one enable per status bit. The interrupt pin is active whenever an enabled status bit is set. A single bit in a second, separate configuration register chooses the active level of the pin.

Software reaches the block through a simple strobe bus: `rd_en`/`wr_en` with a 5-bit register address and 16-bit write data. Read data is registered and appears one cycle after the read strobe. Each status bit is a two-state machine. `LANE_IDLE` means no event is pending. `LANE_SET` means an event has been captured. The transition `LANE_IDLE -> LANE_SET` is taken on an event pulse. The transition `LANE_SET -> LANE_IDLE` is taken on a clearing read that has no coincident event. In every other case the state holds.

Top module: `mgmt_irq_reg`

## Requirements
- R1: A one-cycle pulse on `evt_i[i]` sets status bit i at the next clock edge, whether or not enable bit i is set.
- R2: A set status bit stays set across any number of cycles until the interrupt register (address 0x1B) is read.
- R3: A read of address 0x1B returns {enables[7:0], status[7:0]} on `rd_data` in the cycle after the strobe, and clears all status bits at that same edge.
- R4: An event that arrives in the same cycle as a clearing read leaves its status bit set after the clear. The data returned by that read shows the status as it was before that event.
- R5: A write to address 0x1B loads `wr_data[15:8]` into the enables. `wr_data[7:0]` is ignored and the status bits are unchanged.
- R6: A write to address 0x1F loads `wr_data[9]` as the polarity: 1 means active high, 0 means active low. A read of 0x1F returns the polarity in bit 9 and zero in every other bit.
- R7: `irq_o` is at its active level exactly when (enables AND status) is nonzero, and is at its inactive level otherwise.
- R8: After reset the enables, status and polarity are all 0. `irq_o` is therefore 1 (inactive, low-active), and `rd_data` is 0.
- R9: A write to any other address has no effect. A read of any other address returns 0.
- R10: `rd_data` holds its last value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event pulses, one per status bit |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt pin, polarity per configuration bit |

## Verification
The hardest case to reach is an event pulse landing in exactly the cycle of a clearing read. Getting there needs the read strobe and the pulse to be driven together, and the effect only shows up one read later. The bench drives that collision on purpose. A long stretch of random strobes, addresses and event pulses then produces many more collisions, including ones where the event is masked and ones made while the polarity is flipped. A behavioural model tracks every cycle and compares `irq_o` and `rd_data` on each clock.

// File: rtl/mgmt_irq_pkg.sv
package mgmt_irq_pkg;
    typedef enum logic {
        LANE_IDLE = 1'b0,
        LANE_SET  = 1'b1
    } lane_state_e;
endpackage

// File: rtl/irq_status_lane.sv
module irq_status_lane
    import mgmt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic sts_o
);
    lane_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LANE_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LANE_IDLE: if (evt_i)           st_d = LANE_SET;
            LANE_SET:  if (clr_i && !evt_i) st_d = LANE_IDLE;
            default:                        st_d = LANE_IDLE;
        endcase
    end

    always_comb sts_o = (st_q == LANE_SET);
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
    parameter int          ADDR_W   = 5,
    parameter logic [4:0]  IRQ_ADDR = 5'h1B,
    parameter logic [4:0]  CFG_ADDR = 5'h1F
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_irq,
    output logic              wr_irq,
    output logic              rd_cfg,
    output logic              wr_cfg
);
    logic hit_irq, hit_cfg;
    always_comb begin
        hit_irq = (addr == ADDR_W'(IRQ_ADDR));
        hit_cfg = (addr == ADDR_W'(CFG_ADDR));
        rd_irq  = rd_en && hit_irq;
        wr_irq  = wr_en && hit_irq;
        rd_cfg  = rd_en && hit_cfg;
        wr_cfg  = wr_en && hit_cfg;
    end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_cfg,
    input  logic               pol_wdata,
    input  logic [FIELD_W-1:0] en_i,
    input  logic [FIELD_W-1:0] sts_i,
    output logic               pol_o,
    output logic               irq_o
);
    logic pol_q;
    logic any_pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pol_q <= 1'b0;
        else if (wr_cfg) pol_q <= pol_wdata;
    end

    always_comb begin
        any_pending = |(en_i & sts_i);
        irq_o       = pol_q ? any_pending : !any_pending;
        pol_o       = pol_q;
    end
endmodule

// File: rtl/mgmt_irq_reg.sv
module mgmt_irq_reg #(
    parameter int          N_EVT    = 8,
    parameter int          ADDR_W   = 5,
    parameter int          DATA_W   = 16,
    parameter logic [4:0]  IRQ_ADDR = 5'h1B,
    parameter logic [4:0]  CFG_ADDR = 5'h1F,
    parameter int          POL_BIT  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    localparam int FIELD_W = DATA_W / 2;

    logic               rd_irq, wr_irq, rd_cfg, wr_cfg;
    logic [FIELD_W-1:0] en_q;
    logic [FIELD_W-1:0] sts_q;
    logic               pol_q;
    logic [DATA_W-1:0]  rd_d;
    logic [DATA_W-1:0]  rd_q;

    irq_bus_decode #(
        .ADDR_W  (ADDR_W),
        .IRQ_ADDR(IRQ_ADDR),
        .CFG_ADDR(CFG_ADDR)
    ) u_dec (
        .rd_en (rd_en),
        .wr_en (wr_en),
        .addr  (addr),
        .rd_irq(rd_irq),
        .wr_irq(wr_irq),
        .rd_cfg(rd_cfg),
        .wr_cfg(wr_cfg)
    );

    for (genvar gi = 0; gi < FIELD_W; gi++) begin : g_lane
        if (gi < N_EVT) begin : g_live
            irq_status_lane u_lane (
                .clk  (clk),
                .rst_n(rst_n),
                .evt_i(evt_i[gi]),
                .clr_i(rd_irq),
                .sts_o(sts_q[gi])
            );
        end else begin : g_tie
            assign sts_q[gi] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_irq) en_q <= wr_data[DATA_W-1:FIELD_W];
    end

    irq_pin_drive #(.FIELD_W(FIELD_W)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg   (wr_cfg),
        .pol_wdata(wr_data[POL_BIT]),
        .en_i     (en_q),
        .sts_i    (sts_q),
        .pol_o    (pol_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        rd_d = '0;
        if (rd_irq)      rd_d = {en_q, sts_q};
        else if (rd_cfg) rd_d[POL_BIT] = pol_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_d;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/mgmt_irq_reg_chk.sv
module mgmt_irq_reg_chk #(
    parameter int N_EVT   = 8,
    parameter int FIELD_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_EVT-1:0]   evt_i,
    input logic [FIELD_W-1:0] sts,
    input logic [FIELD_W-1:0] en,
    input logic               pol,
    input logic               rd_hit,
    input logic               wr_hit,
    input logic               irq
);
    logic [FIELD_W-1:0] evt_x;
    assign evt_x = FIELD_W'(evt_i);

    p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_x) |=> ((sts & $past(evt_x)) == $past(evt_x)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (($past(sts) & ~sts) == '0));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && evt_x == '0) |=> (sts == '0));

    p_race_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (sts == $past(evt_x)));

    p_low_byte_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !rd_hit && evt_x == '0) |=> (sts == $past(sts)));

    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & sts) == '0) |-> (irq == !pol));
endmodule

bind mgmt_irq_reg mgmt_irq_reg_chk #(
    .N_EVT  (N_EVT),
    .FIELD_W(FIELD_W)
) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i),
    .sts   (sts_q),
    .en    (en_q),
    .pol   (pol_q),
    .rd_hit(rd_irq),
    .wr_hit(wr_irq),
    .irq   (irq_o)
);

// File: tb/test_mgmt_irq_reg.sv
module test_mgmt_irq_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq_o;

    int vectors = 0;
    int fails   = 0;
    string phase = "R8";
    bit done = 1'b0;

    int m_en = 0, m_sts = 0, m_pol = 0, m_rd = 0;

    always #4 clk = ~clk;

    mgmt_irq_reg i_mgmt_irq_reg (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    // behavioural model, compared two ns after every rising edge
    always @(posedge clk) begin
        int any;
        int exp_irq;
        if (!rst_n) begin
            m_en = 0; m_sts = 0; m_pol = 0; m_rd = 0;
        end else begin
            if (rd_en) begin
                if (addr == 5'h1B)      m_rd = (m_en << 8) | m_sts;
                else if (addr == 5'h1F) m_rd = m_pol << 9;
                else                    m_rd = 0;
            end
            if (rd_en && addr == 5'h1B) m_sts = 0;
            m_sts = m_sts | int'(evt_i);
            if (wr_en && addr == 5'h1B) m_en = int'(wr_data[15:8]);
            if (wr_en && addr == 5'h1F) m_pol = int'(wr_data[9]);
        end
        any = ((m_en & m_sts) != 0) ? 1 : 0;
        exp_irq = (m_pol != 0) ? any : 1 - any;
        #2;
        vectors++;
        if (int'(irq_o) !== exp_irq || int'(rd_data) !== m_rd) begin
            fails++;
            $display("FAIL %s: irq=%0d rd_data=%h expected irq=%0d rd_data=%h",
                     phase, irq_o, rd_data, exp_irq, m_rd[15:0]);
        end
    end

    task automatic cyc(input logic [7:0] ev, input logic rd, input logic wr,
                       input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        evt_i = ev; rd_en = rd; wr_en = wr; addr = a; wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(8'h00, 1'b0, 1'b0, 5'h00, 16'h0000);
    endtask

    initial begin
        phase = "R8"; idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        phase = "R1"; cyc(8'h05, 0, 0, 5'h00, 16'h0); idle(1);
        phase = "R2"; idle(5);
        phase = "R5"; cyc(8'h00, 0, 1, 5'h1B, 16'hFFAA); idle(2);
        phase = "R7"; cyc(8'h00, 0, 1, 5'h1B, 16'h0200); idle(1);
        cyc(8'h00, 0, 1, 5'h1B, 16'h0400); idle(1);
        phase = "R3"; cyc(8'h00, 1, 0, 5'h1B, 16'h0); idle(2);
        phase = "R4"; cyc(8'h01, 0, 1, 5'h1B, 16'hFF00);
        cyc(8'h80, 1, 0, 5'h1B, 16'h0); idle(1);
        cyc(8'h00, 1, 0, 5'h1B, 16'h0); idle(1);
        phase = "R6"; cyc(8'h10, 0, 1, 5'h1F, 16'h0200); idle(1);
        cyc(8'h00, 1, 0, 5'h1F, 16'h0); idle(1);
        cyc(8'h00, 1, 0, 5'h1B, 16'h0); idle(1);
        phase = "R9"; cyc(8'h00, 0, 1, 5'h03, 16'hFFFF);
        cyc(8'h00, 1, 0, 5'h03, 16'h0); idle(1);
        phase = "R10"; cyc(8'h00, 1, 0, 5'h1F, 16'h0); idle(4);
        phase = "R4";
        for (int k = 0; k < 2000; k++) begin
            logic [4:0] ra;
            int sel;
            sel = int'($urandom_range(0, 3));
            ra = (sel == 0) ? 5'h1B : (sel == 1) ? 5'h1F : 5'($urandom);
            cyc(8'($urandom) & 8'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0),
                ra, 16'($urandom));
        end
        idle(2);
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 100000 && !done; k++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule